// File: doc/BRIEF.md
# First-Hit Channel Address Serializer

This block watches the threshold flags of a bank of detector channels. It picks out the first channel that fires once the block is armed. It then sends that channel's index on a one-wire serial line of its own, apart from any full readout path. An external trigger processor can therefore form fast coincidences from the very first hit of an event, without waiting for amplitude data.

A frame is a single start bit followed by the channel index, most significant bit first, at one bit per clock. The line sits low at all other times. Channels can be excluded through a mask. When several eligible channels are high in the same cycle, a select input chooses whether the lowest or the highest index wins. After a frame the block stays locked, so later hits are not reported. It re-arms either on an explicit pulse or once every unmasked flag has fallen back low.

Top module: `fh_addr_out`

## Requirements
- R1: `ser_out` is 0 during reset, after reset, and in every cycle that is not part of a frame.
- R2: A frame is seven consecutive bits on `ser_out`: a 1 start bit, then the 6-bit channel index from bit 5 down to bit 0. The start bit appears in the cycle after the first clock edge at which an eligible flag is sampled while the block is armed.
- R3: With `prio_high` = 0, when several eligible flags are high in the same sampled cycle, the lowest channel index is sent.
- R4: With `prio_high` = 1, when several eligible flags are high in the same sampled cycle, the highest channel index is sent.
- R5: A channel whose `chan_mask` bit is 1 is never sent, and a hit on it alone starts no frame.
- R6: Flag changes and `rearm` pulses that arrive while a frame is being sent leave that frame unchanged.
- R7: After a frame the block sends nothing more while any unmasked flag stays high and no `rearm` pulse arrives.
- R8: A `rearm` pulse while the block is locked re-arms it. If eligible flags are still high, a new frame starts one cycle after the re-arm edge.
- R9: While the block is locked, a cycle in which all unmasked flags are low re-arms it, and a later hit produces a new frame.
- R10: The extreme channels 0 and 63 are encoded as 000000 and 111111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| hit_flags | input | 64 | Per-channel threshold flags, bit i belongs to channel i |
| chan_mask | input | 64 | 1 excludes the channel from selection and from holding the lock |
| prio_high | input | 1 | 0: lowest index wins a tie, 1: highest index wins |
| rearm | input | 1 | One-cycle pulse that releases the lock |
| ser_out | output | 1 | Serial first-hit frame, idles low |

## Verification
The embedded properties check several rules on every cycle. The selected channel must be unmasked, flagged and the extreme of the eligible set in the chosen direction. A load must never arrive while bits are still shifting. The line must be low outside a frame and must carry the start bit right after a load. The lock must hold or release according to `rearm` and the unmasked flags. Only the directed scenarios can show that whole frames carry the correct bits. The same goes for hits or re-arm pulses injected mid-frame, which must leave the frame intact. They also show that the block stays silent while locked and restarts after each release path, with the right timing.

// File: rtl/fh_pkg.sv
package fh_pkg;
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_SEND   = 2'd1,
    ST_LOCKED = 2'd2
  } fh_state_e;
endpackage

// File: rtl/fh_pick.sv
module fh_pick #(
  parameter int NUM_CH = 64,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] elig,
  input  logic              prio_high,
  output logic              vld,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    if (!prio_high) begin
      for (int i = NUM_CH - 1; i >= 0; i--) begin
        if (elig[i]) begin
          vld = 1'b1;
          idx = IDX_W'(i);
        end
      end
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (elig[i]) begin
          vld = 1'b1;
          idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/fh_shift.sv
module fh_shift #(
  parameter int IDX_W = 6,
  localparam int CNT_W = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             load,
  input  logic [IDX_W-1:0] addr,
  output logic             busy,
  output logic             sout
);
  logic [IDX_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sout_q, sout_d;
  logic             upd_en;

  assign busy   = (cnt_q != '0);
  assign upd_en = load | busy | sout_q;

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    sout_d = 1'b0;
    if (load) begin
      sreg_d = addr;
      cnt_d  = CNT_W'(IDX_W);
      sout_d = 1'b1;
    end else if (busy) begin
      sout_d = sreg_q[IDX_W-1];
      sreg_d = {sreg_q[IDX_W-2:0], 1'b0};
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      sout_q <= 1'b0;
    end else if (upd_en) begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      sout_q <= sout_d;
    end
  end

  assign sout = sout_q;

  // R6
  load_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    busy |-> !load);
  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    load |=> sout);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/fh_ctrl.sv
module fh_ctrl
  import fh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sn,
  input  logic      pick_vld,
  input  logic      busy,
  input  logic      rearm,
  input  logic      any_elig,
  output logic      load,
  output fh_state_e state
);
  fh_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    case (state_q)
      ST_ARMED: begin
        if (pick_vld) begin
          load    = 1'b1;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (!busy) state_d = ST_LOCKED;
      end
      ST_LOCKED: begin
        if (rearm || !any_elig) state_d = ST_ARMED;
      end
      default: state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) state_q <= ST_ARMED;
    else         state_q <= state_d;
  end

  assign state = state_q;

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_LOCKED && !rearm && any_elig) |=> (state_q == ST_LOCKED));
  // R8
  rearm_release_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_LOCKED && rearm) |=> (state_q == ST_ARMED));
  // R9
  quiet_release_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_LOCKED && !any_elig) |=> (state_q == ST_ARMED));
endmodule

// File: rtl/fh_addr_out.sv
module fh_addr_out
  import fh_pkg::*;
#(
  parameter int NUM_CH = 64,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit_flags,
  input  logic [NUM_CH-1:0] chan_mask,
  input  logic              prio_high,
  input  logic              rearm,
  output logic              ser_out
);
  logic [1:0]        rst_sync_q;
  logic              rst_sn;
  logic [NUM_CH-1:0] elig;
  logic              any_elig;
  logic              pick_vld;
  logic [IDX_W-1:0]  pick_idx;
  logic              load;
  logic              busy;
  fh_state_e         state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign elig     = hit_flags & ~chan_mask;
  assign any_elig = |elig;

  fh_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
    .elig      (elig),
    .prio_high (prio_high),
    .vld       (pick_vld),
    .idx       (pick_idx)
  );

  fh_ctrl u_ctrl (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .pick_vld (pick_vld),
    .busy     (busy),
    .rearm    (rearm),
    .any_elig (any_elig),
    .load     (load),
    .state    (state)
  );

  fh_shift #(.IDX_W(IDX_W)) u_shift (
    .clk    (clk),
    .rst_sn (rst_sn),
    .load   (load),
    .addr   (pick_idx),
    .busy   (busy),
    .sout   (ser_out)
  );

  // R5
  pick_eligible_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    pick_vld |-> (hit_flags[pick_idx] && !chan_mask[pick_idx]));
  // R3
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (pick_vld && !prio_high) |->
      ((elig & ((NUM_CH'(1) << pick_idx) - NUM_CH'(1))) == '0));
  // R4
  pick_highest_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (pick_vld && prio_high) |->
      ((elig & ~((NUM_CH'(2) << pick_idx) - NUM_CH'(1))) == '0));
  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state != ST_SEND) |-> !ser_out);
endmodule

// File: tb/fh_addr_out_test.sv
module fh_addr_out_test;
  logic        clk;
  logic        rst_n;
  logic [63:0] hit_flags;
  logic [63:0] chan_mask;
  logic        prio_high;
  logic        rearm;
  logic        ser_out;
  int          checks;
  int          errors;
  bit          done;

  fh_addr_out uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_flags (hit_flags),
    .chan_mask (chan_mask),
    .prio_high (prio_high),
    .rearm     (rearm),
    .ser_out   (ser_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_frame(input int ch, input string req);
    logic [6:0] got;
    for (int b = 0; b < 7; b++) begin
      @(negedge clk);
      got[6-b] = ser_out;
    end
    check({25'd0, got}, {25'd0, 1'b1, 6'(ch)}, req);
    @(negedge clk);
    check({31'd0, ser_out}, 32'd0, "R1 line low after frame");
  endtask

  task automatic expect_quiet(input int n, input string req);
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      seen = seen | ser_out;
    end
    check({31'd0, seen}, 32'd0, req);
  endtask

  task automatic settle();
    hit_flags = '0;
    rearm     = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hit_flags = '0; chan_mask = '0; prio_high = 1'b0; rearm = 1'b0;
    repeat (3) @(negedge clk);
    check({31'd0, ser_out}, 32'd0, "R1 reset");
    rst_n = 1'b1;
    expect_quiet(5, "R1 idle after reset");
  endtask

  task automatic t_single();
    settle();
    hit_flags[5] = 1'b1;
    expect_frame(5, "R2 single hit ch5");
  endtask

  task automatic t_tie();
    settle();
    prio_high = 1'b0;
    hit_flags[10] = 1'b1; hit_flags[40] = 1'b1;
    expect_frame(10, "R3 lowest wins");
    settle();
    prio_high = 1'b1;
    hit_flags[10] = 1'b1; hit_flags[40] = 1'b1;
    expect_frame(40, "R4 highest wins");
    settle();
    chan_mask[40] = 1'b1;
    hit_flags[10] = 1'b1; hit_flags[40] = 1'b1;
    expect_frame(10, "R4 R5 masked top skipped");
    settle();
    chan_mask = '0; prio_high = 1'b0;
  endtask

  task automatic t_mask();
    settle();
    chan_mask[3] = 1'b1;
    hit_flags[3] = 1'b1;
    expect_quiet(10, "R5 masked alone silent");
    hit_flags[7] = 1'b1;
    expect_frame(7, "R5 masked ch3 skipped");
    settle();
    chan_mask = '0;
  endtask

  task automatic t_mid_and_lock();
    settle();
    hit_flags[20] = 1'b1;
    fork
      begin
        repeat (3) @(negedge clk);
        hit_flags[1] = 1'b1;
      end
      expect_frame(20, "R6 hit during frame");
    join
    expect_quiet(12, "R7 locked while flags high");
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    expect_frame(1, "R8 rearm restarts");
    expect_quiet(6, "R7 locked after rearm frame");
  endtask

  task automatic t_rearm_in_frame();
    settle();
    hit_flags[33] = 1'b1;
    fork
      begin
        repeat (2) @(negedge clk);
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
      end
      expect_frame(33, "R6 rearm during frame");
    join
    expect_quiet(8, "R6 rearm in frame ignored");
  endtask

  task automatic t_quiet_release();
    settle();
    hit_flags[63] = 1'b1;
    expect_frame(63, "R9 R10 ch63 after quiet release");
    settle();
    hit_flags[0] = 1'b1;
    expect_frame(0, "R10 ch0");
    settle();
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    t_reset();
    t_single();
    t_tie();
    t_mask();
    t_mid_and_lock();
    t_rearm_in_frame();
    t_quiet_release();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule